// File: doc/BRIEF.md
# Prioritized Interrupt Selector

This block holds a small set of pending interrupt requests and, every clock cycle, picks the single most urgent request that may be taken now. Each request source has its own latch, which a one-cycle set pulse turns on and a one-cycle clear pulse turns off. A fixed ranking decides among requests that are ready. Each source also has its own gating condition, built from a handful of core state bits: external enable, critical enable, hypervisor state, hypervisor-decrementer enable and external routing. The winner's index comes out as a cause code together with a valid strobe, one cycle after the pending state and enables that produced it.

When a request is taken, some sources drop their pending latch. Level-driven sources keep it until the requester withdraws it with a clear pulse. The decrementer drops its latch only when a configuration input asks for that. A power-save entry pulse throws away any pending hypervisor-decrementer request. Building the exception frame and computing the handler address are left to the logic that consumes the cause code.

Top module: `irq_selector`

## Requirements
- R1: Sources are ranked by cause code, lowest wins: 0 reset, 1 machine check, 2 hypervisor decrementer, 3 external, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable-interval timer, 9 decrementer, 10 doorbell, 11 performance monitor, 12 thermal; set/clear/pending bit i belongs to cause code i.
- R2: Codes 0 and 1 are taken whatever the enables are, and their pending bit is cleared when taken.
- R3: Code 2 is taken only when `hdec_en_i` is 1 and either `ext_en_i` is 1 or `hv_state_i` is 0; its pending bit is cleared when taken.
- R4: Code 3 is taken when `ext_en_i` is 1, or when the HAS_HV parameter is 1, `hv_state_i` is 0 and `ext_to_hv_i` is 0; taking it leaves its pending bit set.
- R5: Code 4 is taken only when `crit_en_i` is 1; taking it leaves its pending bit set.
- R6: Codes 5, 6, 7, 8, 10, 11 and 12 are taken only when `ext_en_i` is 1, and their pending bit is cleared when taken.
- R7: Code 9 is taken only when `ext_en_i` is 1; its pending bit is cleared when taken only if `dec_clr_cfg_i` is 1.
- R8: A `pwr_save_i` pulse clears pending bit 2.
- R9: When no pending request may be taken, `valid_o` is 0 and `cause_o` is 0 in the following cycle.
- R10: A set pulse on a bit wins over a delivery clear, a clear pulse and a power-save discard in the same cycle: the bit is 1 afterwards.
- R11: A clear pulse drops the pending bit at the next edge; `valid_o`/`cause_o` reflect the pending state and enables of the previous cycle.
- R12: During and right after synchronous reset, `pending_o`, `valid_o` and `cause_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_i | input | 13 | Per-source set pulses |
| clr_i | input | 13 | Per-source clear pulses |
| ext_en_i | input | 1 | External interrupt enable |
| crit_en_i | input | 1 | Critical interrupt enable |
| hv_state_i | input | 1 | Core is in hypervisor state |
| hdec_en_i | input | 1 | Hypervisor decrementer enable |
| ext_to_hv_i | input | 1 | External routing bit; 0 lets external bypass the enable outside hypervisor state |
| dec_clr_cfg_i | input | 1 | Decrementer clears on delivery when 1 |
| pwr_save_i | input | 1 | Power-save entry pulse |
| valid_o | output | 1 | A cause is being issued |
| cause_o | output | 4 | Cause code of the issued request |
| pending_o | output | 13 | Current pending latches |

## Verification
Every source is raised alone under all 64 combinations of the six gating and configuration inputs. This separates each source's own gating rule and its clear-on-delivery policy from those of the others. Every ordered pair of sources is then raised together with all enables on and with external enable off, which exposes any wrong ranking and any gating that leaks between neighbours. Long random runs drive sets, clears and power-save pulses at once, so that set-versus-clear collisions and changes of the enables in the middle of a request are checked against a cycle model.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int NSRC = 13;
  localparam int CW   = $clog2(NSRC);

  localparam int IDX_RST   = 0;
  localparam int IDX_MCK   = 1;
  localparam int IDX_HDEC  = 2;
  localparam int IDX_EXT   = 3;
  localparam int IDX_CEXT  = 4;
  localparam int IDX_DEC   = 9;

  typedef enum logic [1:0] {
    CLR_ALWAYS = 2'd0,
    CLR_NEVER  = 2'd1,
    CLR_CFG    = 2'd2
  } clr_pol_e;

  // clear-on-delivery policy per source
  function automatic clr_pol_e clr_policy(int idx);
    if (idx == IDX_EXT || idx == IDX_CEXT) return CLR_NEVER;
    if (idx == IDX_DEC) return CLR_CFG;
    return CLR_ALWAYS;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst)           q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;   // set beats every clear source
      else if (clr_i[i]) q <= 1'b0;
    end
    assign pend_o[i] = q;
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
#(
  parameter int N      = NSRC,
  parameter bit HAS_HV = 1'b1
) (
  input  logic [N-1:0] pend_i,
  input  logic         ext_en_i,
  input  logic         crit_en_i,
  input  logic         hv_state_i,
  input  logic         hdec_en_i,
  input  logic         ext_to_hv_i,
  input  logic         dec_clr_cfg_i,
  output logic [N-1:0] elig_o,
  output logic [N-1:0] autoclr_o
);
  logic hdec_ok, ext_ok;
  assign hdec_ok = hdec_en_i && (ext_en_i || !hv_state_i);
  assign ext_ok  = ext_en_i || (HAS_HV && !hv_state_i && !ext_to_hv_i);

  for (genvar i = 0; i < N; i++) begin : g_src
    logic en;
    if (i == IDX_RST || i == IDX_MCK) begin : g_nmi
      assign en = 1'b1;
    end else if (i == IDX_HDEC) begin : g_hdec
      assign en = hdec_ok;
    end else if (i == IDX_EXT) begin : g_ext
      assign en = ext_ok;
    end else if (i == IDX_CEXT) begin : g_cext
      assign en = crit_en_i;
    end else begin : g_ee
      assign en = ext_en_i;
    end
    assign elig_o[i] = pend_i[i] && en;

    if (clr_policy(i) == CLR_NEVER) begin : g_keep
      assign autoclr_o[i] = 1'b0;
    end else if (clr_policy(i) == CLR_CFG) begin : g_cfg
      assign autoclr_o[i] = dec_clr_cfg_i;
    end else begin : g_clr
      assign autoclr_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N  = 13,
  parameter int CW = $clog2(N)
) (
  input  logic [N-1:0]  elig_i,
  output logic          any_o,
  output logic [CW-1:0] idx_o,
  output logic [N-1:0]  grant_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        any_o = 1'b1;
        idx_o = CW'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) grant_o[i] = any_o && (idx_o == CW'(i));
  end
endmodule

// File: rtl/irq_selector.sv
module irq_selector
  import irq_sel_pkg::*;
#(
  parameter bit HAS_HV = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            ext_en_i,
  input  logic            crit_en_i,
  input  logic            hv_state_i,
  input  logic            hdec_en_i,
  input  logic            ext_to_hv_i,
  input  logic            dec_clr_cfg_i,
  input  logic            pwr_save_i,
  output logic            valid_o,
  output logic [CW-1:0]   cause_o,
  output logic [NSRC-1:0] pending_o
);
  logic [NSRC-1:0] pend, elig, autoclr, grant, pmask, clr_all;
  logic            any;
  logic [CW-1:0]   idx;

  irq_gate #(.N(NSRC), .HAS_HV(HAS_HV)) u_gate (
    .pend_i(pend), .ext_en_i(ext_en_i), .crit_en_i(crit_en_i),
    .hv_state_i(hv_state_i), .hdec_en_i(hdec_en_i),
    .ext_to_hv_i(ext_to_hv_i), .dec_clr_cfg_i(dec_clr_cfg_i),
    .elig_o(elig), .autoclr_o(autoclr)
  );

  irq_prio #(.N(NSRC), .CW(CW)) u_prio (
    .elig_i(elig), .any_o(any), .idx_o(idx), .grant_o(grant)
  );

  always_comb begin
    pmask = '0;
    pmask[IDX_HDEC] = pwr_save_i;
  end

  assign clr_all = (grant & autoclr) | clr_i | pmask;

  irq_pend_bank #(.N(NSRC)) u_bank (
    .clk(clk), .rst(rst), .set_i(set_i), .clr_i(clr_all), .pend_o(pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      cause_o <= '0;
    end else begin
      valid_o <= any;
      cause_o <= idx;
    end
  end

  assign pending_o = pend;
endmodule

// File: rtl/irq_selector_chk.sv
module irq_selector_chk
  import irq_sel_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] set_i,
  input logic [NSRC-1:0] clr_i,
  input logic            ext_en_i,
  input logic            crit_en_i,
  input logic            hv_state_i,
  input logic            hdec_en_i,
  input logic            ext_to_hv_i,
  input logic            dec_clr_cfg_i,
  input logic            pwr_save_i,
  input logic            valid_o,
  input logic [CW-1:0]   cause_o,
  input logic [NSRC-1:0] pending_o
);
  p_rst_first_r2: assert property (@(posedge clk) disable iff (rst)
    pending_o[IDX_RST] |=> (valid_o && cause_o == CW'(IDX_RST)));

  p_mck_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (pending_o[IDX_MCK] && !pending_o[IDX_RST] && !set_i[IDX_MCK]) |=> !pending_o[IDX_MCK]);

  p_hdec_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !hdec_en_i |=> !(valid_o && cause_o == CW'(IDX_HDEC)));

  p_ext_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (pending_o[IDX_EXT] && !clr_i[IDX_EXT]) |=> pending_o[IDX_EXT]);

  p_cext_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (pending_o[IDX_CEXT] && !clr_i[IDX_CEXT]) |=> pending_o[IDX_CEXT]);

  p_pwr_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (pwr_save_i && !set_i[IDX_HDEC]) |=> !pending_o[IDX_HDEC]);

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (pending_o == '0) |=> !valid_o);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    set_i[IDX_HDEC] |=> pending_o[IDX_HDEC]);

  p_cause_range_r1: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (cause_o < CW'(NSRC)));
endmodule

bind irq_selector irq_selector_chk u_chk (.*);

// File: tb/tb_irq_selector.sv
module tb_irq_selector;
  localparam int N = 13;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] s_set = '0, s_clr = '0;
  logic ee = 0, ce = 0, hv = 0, hden = 0, route = 0, deccfg = 0, pwr = 0;
  logic valid;
  logic [CW-1:0] cause;
  logic [N-1:0] pend;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [N-1:0] m_pend = '0;
  logic m_valid = 0;
  logic [CW-1:0] m_cause = '0;

  always #4 clk = ~clk;

  irq_selector #(.HAS_HV(1'b1)) dut (
    .clk(clk), .rst(rst), .set_i(s_set), .clr_i(s_clr),
    .ext_en_i(ee), .crit_en_i(ce), .hv_state_i(hv), .hdec_en_i(hden),
    .ext_to_hv_i(route), .dec_clr_cfg_i(deccfg), .pwr_save_i(pwr),
    .valid_o(valid), .cause_o(cause), .pending_o(pend)
  );

  function automatic string req_of(int i);
    if (i <= 1) return "R2";
    if (i == 2) return "R3";
    if (i == 3) return "R4";
    if (i == 4) return "R5";
    if (i == 9) return "R7";
    return "R6";
  endfunction

  function automatic bit may_take(int i);
    case (i)
      0, 1: return 1'b1;
      2: return hden && (ee || !hv);
      3: return ee || (!hv && !route);
      4: return ce;
      default: return ee;
    endcase
  endfunction

  function automatic bit drops(int i);
    if (i == 3 || i == 4) return 1'b0;
    if (i == 9) return deccfg;
    return 1'b1;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: inputs already driven; advance model and compare
  task automatic step(string tag = "");
    logic [N-1:0] np, cm;
    logic nv;
    logic [CW-1:0] nc;
    string t;
    nv = 0; nc = '0;
    for (int i = N - 1; i >= 0; i--)
      if (m_pend[i] && may_take(i)) begin nv = 1; nc = CW'(i); end
    cm = s_clr;
    if (pwr) cm[2] = 1'b1;
    if (nv && drops(int'(nc))) cm[nc] = 1'b1;
    np = (m_pend & ~cm) | s_set;
    @(posedge clk);
    @(negedge clk);
    m_pend = np; m_valid = nv; m_cause = nc;
    t = (tag != "") ? tag : (nv ? req_of(int'(nc)) : "R9");
    chk(valid == m_valid, t, "valid", valid, m_valid);
    chk(cause == m_cause, t, "cause", cause, m_cause);
    for (int i = 0; i < N; i++)
      if (pend[i] !== m_pend[i])
        chk(0, (tag != "") ? tag : req_of(i), $sformatf("pending[%0d]", i), pend[i], m_pend[i]);
    checks++;
  endtask

  task automatic idle();
    s_set = '0; s_clr = '0; pwr = 0;
  endtask

  task automatic flush();
    idle(); s_clr = '1; step("R11"); idle();
  endtask

  task automatic set_enables(int c);
    {ee, ce, hv, hden, route, deccfg} = 6'(c);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(valid == 0 && cause == 0 && pend == 0, "R12", "reset outputs", {valid, cause, pend}, 0);
    s_set = '1;
    @(negedge clk);
    chk(pend == 0, "R12", "pending under reset", pend, 0);
    s_set = '0;
    rst = 0;
    @(negedge clk);
    chk(valid == 0 && pend == 0, "R12", "after reset", {valid, pend}, 0);

    // single source across every enable combination
    for (int s = 0; s < N; s++)
      for (int c = 0; c < 64; c++) begin
        flush();
        set_enables(c);
        s_set[s] = 1'b1; step();
        idle(); step(); step();
      end

    // every pair, all enables on and with external enable off (priority)
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        for (int c = 0; c < 2; c++) begin
          flush();
          set_enables(c == 0 ? 6'b111101 : 6'b010101);
          s_set[a] = 1'b1; s_set[b] = 1'b1; step("R1");
          idle(); step("R1"); step("R1");
        end

    // directed: set beats delivery clear, clear pulse and power-save
    flush(); set_enables(6'b100100);
    s_set[2] = 1'b1; step("R10");
    idle(); s_set[2] = 1'b1; s_clr[2] = 1'b1; pwr = 1; step("R10");
    chk(pend[2] == 1, "R10", "hdec kept", pend[2], 1);
    idle(); pwr = 1; step("R8");
    chk(pend[2] == 0, "R8", "hdec discarded", pend[2], 0);
    idle(); s_set[3] = 1'b1; step("R11");
    idle(); s_clr[3] = 1'b1; step("R11");
    chk(pend[3] == 0, "R11", "ext cleared", pend[3], 0);
    idle(); step("R11");

    // random traffic
    for (int k = 0; k < 20000; k++) begin
      s_set = N'($urandom) & N'($urandom) & N'($urandom);
      s_clr = N'($urandom) & N'($urandom);
      pwr = ($urandom % 8) == 0;
      set_enables(int'($urandom % 64));
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule